// File: doc/BRIEF.md
# Programmable Dual Output Clock Divider

This block divides a fast oscillator clock down to two output clocks. A 3-bit code selects the ratio of the primary output. A secondary output runs sixteen times slower than the primary and is built from primary periods. Each output has a true pin and a complementary pin.

The ratio code is only taken up at the start of a primary period, so moving from one ratio to another never produces a short pulse. A ratio of one passes the input clock through. It is switched in and out while the clock is low, so no glitch appears when the path changes.

An active-high master reset holds all counters. While it is high, the true outputs are low and the complementary outputs are high. When it is released, both outputs start a fresh period from the low phase.

Top module: `dual_clock_divider`

## Requirements
- R1: The code `div_code[2:0]` selects the primary ratio: 3'b000→2, 3'b001→4, 3'b010→8, 3'b011→16, 3'b100→1, 3'b101→2, 3'b110→4, 3'b111→8.
- R2: For a ratio R of 2 or more, each primary period spans R rising edges of `vco_clk`: R/2 edges low, then R/2 edges high (50% duty).
- R3: For ratio 1, the primary output follows `vco_clk`. Entry and exit switch the path only while `vco_clk` is low.
- R4: The secondary output changes only at the start of a primary period. It is low for 8 primary periods and then high for 8.
- R5: A change of `div_code` in the middle of a period has no effect until the next period starts; that period uses the new ratio.
- R6: While `mreset` is high, `pri_out` and `sec_out` are low and `pri_out_n` and `sec_out_n` are high.
- R7: After `mreset` falls, the first rising edge of `vco_clk` starts a primary period in its low phase. The secondary output stays low for the first 8 primary periods.
- R8: `pri_out_n` is always the inverse of `pri_out`, and `sec_out_n` is always the inverse of `sec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast input clock to be divided |
| mreset | input | 1 | Active-high master reset |
| div_code | input | 3 | Primary ratio select code |
| pri_out | output | 1 | Primary divided clock, true |
| pri_out_n | output | 1 | Primary divided clock, complement |
| sec_out | output | 1 | Secondary clock (primary ÷16), true |
| sec_out_n | output | 1 | Secondary clock (primary ÷16), complement |

## Verification
The counter, the primary level, the secondary level and the latched code all settle on the rising edge of `vco_clk` that follows a stimulus. The divide-by-one gate settles on the falling edge after that. A reference process runs on every rising edge. It reads the inputs and pushes the levels expected just after that edge. For the gate, it uses the ratio that was in force one edge earlier. A monitor pops each expected item a quarter period after the same edge, while the clock is high. It compares the item with the ports there, so bypass mode reads the high half of the clock. Codes are changed only just after falling edges, which puts every code change in the middle of a period.

// File: rtl/dual_clock_divider.sv
module dual_clock_divider #(
  parameter int CNT_W   = 4,
  parameter int SEC_DIV = 16
) (
  input  logic       vco_clk,
  input  logic       mreset,
  input  logic [2:0] div_code,
  output logic       pri_out,
  output logic       pri_out_n,
  output logic       sec_out,
  output logic       sec_out_n
);
  localparam int SEC_W = $clog2(SEC_DIV);

  function automatic logic [CNT_W-1:0] last_of(input logic [2:0] c);
    case (c)
      3'b000:  return CNT_W'(1);
      3'b001:  return CNT_W'(3);
      3'b010:  return CNT_W'(7);
      3'b011:  return CNT_W'(15);
      3'b100:  return CNT_W'(0);
      3'b101:  return CNT_W'(1);
      3'b110:  return CNT_W'(3);
      default: return CNT_W'(7);
    endcase
  endfunction

  logic [2:0]       act_code;
  logic [CNT_W-1:0] cnt, cnt_nx, last, half;
  logic [CNT_W:0]   ratio;
  logic [SEC_W-1:0] pc, pc_inc;
  logic             wrap, div_q, byp_q, sec_q;

  assign last   = last_of(act_code);
  assign ratio  = {1'b0, last} + 1'b1;
  assign half   = ratio[CNT_W:1];
  assign wrap   = (cnt == last);
  assign cnt_nx = wrap ? '0 : cnt + 1'b1;
  assign pc_inc = pc + 1'b1;

  always_ff @(posedge vco_clk) begin
    if (mreset) begin
      act_code <= div_code;
      cnt      <= last_of(div_code);
      div_q    <= 1'b0;
      pc       <= '1;
      sec_q    <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      div_q <= !wrap && (cnt_nx >= half);
      if (wrap) begin
        act_code <= div_code;
        pc       <= pc_inc;
        sec_q    <= pc_inc[SEC_W-1];
      end
    end
  end

  always_ff @(negedge vco_clk)
    byp_q <= (act_code == 3'b100);

  assign pri_out   = ~mreset & (byp_q ? vco_clk : div_q);
  assign pri_out_n = ~pri_out;
  assign sec_out   = ~mreset & sec_q;
  assign sec_out_n = ~sec_out;

  // R2
  half_point_chk: assert property (@(posedge vco_clk) disable iff (mreset)
    $rose(div_q) |-> (cnt == half));
  // R2
  cnt_range_chk: assert property (@(posedge vco_clk) disable iff (mreset)
    cnt <= last);
  // R5
  code_hold_chk: assert property (@(posedge vco_clk) disable iff (mreset)
    !wrap |=> $stable(act_code));
  // R4
  sec_edge_chk: assert property (@(posedge vco_clk) disable iff (mreset)
    !$stable(sec_q) |-> $past(wrap));
  // R7
  period_start_low_chk: assert property (@(posedge vco_clk) disable iff (mreset)
    wrap |=> !div_q);
endmodule

// File: tb/tb_dual_clock_divider.sv
module tb_dual_clock_divider;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] code = 3'b000;
  logic       pri_out, pri_out_n, sec_out, sec_out_n;

  dual_clock_divider dut (
    .vco_clk(clk), .mreset(rst), .div_code(code),
    .pri_out(pri_out), .pri_out_n(pri_out_n),
    .sec_out(sec_out), .sec_out_n(sec_out_n)
  );

  always #(PER/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R6";

  logic [1:0] exp_q[$];
  string      ptag_q[$];
  string      stag_q[$];

  // R1 ratio table
  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'b000: return 2;
      3'b001: return 4;
      3'b010: return 8;
      3'b011: return 16;
      3'b100: return 1;
      3'b101: return 2;
      3'b110: return 4;
      default: return 8;
    endcase
  endfunction

  int         m_R = 2, m_cnt = 1, old_R = 2;
  logic [3:0] m_pc = 4'hf;
  logic       m_sec = 1'b0, m_div = 1'b0, m_byp = 1'b0;

  always @(posedge clk) begin
    old_R = m_R;
    if (rst) begin
      m_R = ratio_of(code); m_cnt = m_R - 1; m_pc = 4'hf; m_sec = 1'b0; m_div = 1'b0;
    end else if (m_cnt == m_R - 1) begin
      m_cnt = 0; m_pc = m_pc + 4'd1; m_sec = m_pc[3]; m_R = ratio_of(code); m_div = 1'b0;
    end else begin
      m_cnt = m_cnt + 1; m_div = (m_cnt >= m_R / 2);
    end
    m_byp = (old_R == 1);
    if (rst) begin
      exp_q.push_back(2'b00); ptag_q.push_back("R6"); stag_q.push_back("R6");
    end else begin
      exp_q.push_back({m_byp ? 1'b1 : m_div, m_sec});
      ptag_q.push_back(m_byp ? "R3" : phase);
      stag_q.push_back(phase == "R7" ? "R7" : "R4");
    end
  end

  task automatic check(input logic a, input logic e, input string t, input string what);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", t, what, a, e, $time);
    end
  endtask

  always @(posedge clk) begin
    #(PER/4);
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string pt, st;
      e = exp_q.pop_front(); pt = ptag_q.pop_front(); st = stag_q.pop_front();
      check(pri_out, e[1], pt, "pri_out");
      check(sec_out, e[0], st, "sec_out");
      check(pri_out_n, ~pri_out, "R8", "pri_out_n");
      check(sec_out_n, ~sec_out, "R8", "sec_out_n");
    end
  end

  task automatic run(input logic [2:0] c, input int n, input string tag);
    @(negedge clk); #1;
    code = c; phase = tag;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_reset(input logic [2:0] c, input int n);
    @(negedge clk); #1;
    rst = 1'b1; code = c; phase = "R6";
    repeat (n) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(PER * 200000);
    n_bad++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    hold_reset(3'b000, 4);
    run(3'b000, 40, "R7");
    run(3'b001, 140, "R2");
    run(3'b010, 200, "R2");
    run(3'b011, 300, "R2");
    run(3'b101, 80, "R1");
    run(3'b110, 150, "R1");
    run(3'b111, 150, "R1");
    run(3'b011, 5, "R5");
    run(3'b001, 40, "R5");
    run(3'b100, 40, "R3");
    run(3'b010, 40, "R3");
    hold_reset(3'b110, 3);
    run(3'b110, 60, "R7");
    hold_reset(3'b100, 3);
    run(3'b100, 20, "R7");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule